// File: doc/BRIEF.md
# Sequential GF(2^8) Multiplicative Inverse Unit

This unit returns the multiplicative inverse of one byte in the binary field of 256 elements, with reduction modulo x^8 + x^4 + x^3 + x + 1 (0x11B). It does not hold a lookup table. It raises the operand to the power 254, which is the inverse of every nonzero element. The exponent bits are scanned from the most significant bit down, and one field multiplier is time-shared between the square step and the multiply step.

A caller pulses `start_i` together with `operand_i`. The unit then raises `busy_o`, and after a fixed number of cycles it pulses `done_o` for one cycle while presenting the answer on `result_o`. Every operand takes the same number of cycles, including zero, so the schedule does not reveal the data. `result_o` keeps its value until the next operation finishes.

Top module: `gf_inv_engine`

## Requirements
- R1: Field arithmetic reduces modulo 0x11B. For example, 0x02 gives 0x8D, 0x03 gives 0xF6, 0x10 gives 0x74 and 0x95 gives 0x8A.
- R2: Operand 0x00 gives result 0x00, and operand 0x01 gives result 0x01.
- R3: For all 256 operands, the result equals the field inverse, which is the value y with x*y = 1, and 0 for x = 0.
- R4: For every nonzero operand, the field product of the operand and the result is 0x01.
- R5: `done_o` is high after exactly the 16th rising edge following the edge that accepts `start_i`. This holds for every operand, 0x00 included.
- R6: `done_o` is high for a single cycle. `busy_o` is high from the accepting edge until `done_o` rises, and it is low while `done_o` is high.
- R7: A start pulse that arrives while `busy_o` is high is ignored. The running operation keeps its operand and its timing.
- R8: `result_o` changes only on the edge that raises `done_o`. Between completions it holds its value.
- R9: After synchronous reset, `busy_o`, `done_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts an operation when the unit is idle |
| operand_i | input | 8 | Byte to invert, sampled when a start is accepted |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Inverse of the last completed operand |

## Verification
The bench sweeps all 256 operands and compares each result with an inverse found by brute-force search over an independent multiplier. A wrong reduction polynomial or a swapped square/multiply order shows up as wrong values at most operands. Operand zero gets separate attention: a design with an early exit for zero would finish early, and one that handled zero wrongly would return a nonzero value. A second start issued in the middle of a run catches a design that restarts or swaps its operand. Waiting several cycles after completion catches a result register that drifts, or a done signal that stays high.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

  typedef enum logic {
    PH_SQR = 1'b0,
    PH_MUL = 1'b1
  } phase_e;

  // Exponent that yields the inverse: 2^w - 2 (all ones except bit 0).
  function automatic int unsigned inv_exponent(input int unsigned w);
    return (1 << w) - 2;
  endfunction

endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int unsigned W    = 8,
  parameter logic [W:0]  POLY = 9'h11B
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  // Horner style: walk b from its top bit, shift-reduce, then add a.
  logic [W-1:0] part [0:W];

  assign part[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_row
    logic [W-1:0] shifted;
    assign shifted   = {part[k][W-2:0], 1'b0} ^ (part[k][W-1] ? POLY[W-1:0] : '0);
    assign part[k+1] = shifted ^ (b_i[W-1-k] ? a_i : '0);
  end

  assign p_o = part[W];

endmodule

// File: rtl/gf_inv_seq.sv
module gf_inv_seq
  import gfinv_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 load_o,
  output logic                 last_o,
  output phase_e               phase_o,
  output logic [$clog2(W)-1:0] bit_idx_o
);

  localparam int unsigned STEPS = 2 * W;
  localparam int unsigned CW    = $clog2(STEPS);
  localparam int unsigned BW    = $clog2(W);

  logic [CW-1:0] step_q;
  logic          busy_q;
  logic          done_q;

  assign load_o    = start_i && !busy_q;
  assign last_o    = busy_q && (step_q == CW'(STEPS - 1));
  assign phase_o   = step_q[0] ? PH_MUL : PH_SQR;
  assign bit_idx_o = BW'(W - 1) - BW'(step_q >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/gf_inv_dp.sv
module gf_inv_dp
  import gfinv_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter logic [W:0]  POLY = 9'h11B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         busy_i,
  input  logic         last_i,
  input  phase_e       phase_i,
  input  logic         exp_bit_i,
  input  logic [W-1:0] operand_i,
  output logic [W-1:0] result_o
);

  logic [W-1:0] base_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] res_q;
  logic [W-1:0] mul_b;
  logic [W-1:0] prod;
  logic         take;

  // One shared multiplier: acc*acc on square steps, acc*base on multiply steps.
  assign mul_b = (phase_i == PH_MUL) ? base_q : acc_q;

  gf_mul #(.W(W), .POLY(POLY)) u_mul (
    .a_i (acc_q),
    .b_i (mul_b),
    .p_o (prod)
  );

  assign take = (phase_i == PH_SQR) || exp_bit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else if (load_i) begin
      base_q <= operand_i;
      acc_q  <= W'(1);
    end else if (busy_i) begin
      if (take) acc_q <= prod;
      if (last_i) res_q <= take ? prod : acc_q;
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/gf_inv_engine.sv
module gf_inv_engine
  import gfinv_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter logic [W:0]  POLY = 9'h11B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int unsigned BW  = $clog2(W);
  localparam logic [W-1:0] EXP = W'(inv_exponent(W));

  logic          load;
  logic          last;
  phase_e        phase;
  logic [BW-1:0] bit_idx;
  logic          exp_bit;

  gf_inv_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .load_o    (load),
    .last_o    (last),
    .phase_o   (phase),
    .bit_idx_o (bit_idx)
  );

  assign exp_bit = EXP[bit_idx];

  gf_inv_dp #(.W(W), .POLY(POLY)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .busy_i    (busy_o),
    .last_i    (last),
    .phase_i   (phase),
    .exp_bit_i (exp_bit),
    .operand_i (operand_i),
    .result_o  (result_o)
  );

endmodule

// File: rtl/gf_inv_engine_chk.sv
module gf_inv_engine_chk #(
  parameter int unsigned W    = 8,
  parameter logic [W:0]  POLY = 9'h11B
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [W-1:0] operand_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);

  localparam int unsigned LAT = 2 * W;
  localparam int unsigned KW  = $clog2(LAT) + 2;

  function automatic logic [W-1:0] fmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x = a;
    logic [W-1:0] s = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) s = s ^ x;
      x = x[W-1] ? ({x[W-2:0], 1'b0} ^ POLY[W-1:0]) : {x[W-2:0], 1'b0};
    end
    return s;
  endfunction

  logic [W-1:0]  op_q;
  logic [KW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      cnt_q <= '0;
    end else if (start_i && !busy_o) begin
      op_q  <= operand_i;
      cnt_q <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RESULT_INVERSE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((op_q == '0) ? (result_o == '0) : (fmul(op_q, result_o) == W'(1)))); // R4

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt_q == KW'(LAT))); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R6

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && (cnt_q < KW'(LAT - 1))) |=> (busy_o && !done_o)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o)); // R8

endmodule

bind gf_inv_engine gf_inv_engine_chk #(.W(W), .POLY(POLY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .operand_i (operand_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/test_gf_inv_engine.sv
`timescale 1ns/1ps
module test_gf_inv_engine;

  localparam int LAT_NEG = 17; // negedges from drive to done (16 rising edges after accept)

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] opnd = '0;
  logic       busy;
  logic       done;
  logic [7:0] result;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gf_inv_engine i_gf_inv_engine (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .operand_i (opnd),
    .busy_o    (busy),
    .done_o    (done),
    .result_o  (result)
  );

  // operand in [15:8], expected inverse in [7:0]
  localparam logic [15:0] VEC [12] = '{
    16'h0000, 16'h0101, 16'h028D, 16'h03F6, 16'h1074, 16'h958A,
    16'hFF1C, 16'h8083, 16'h53CA, 16'h0FC7, 16'hA5B8, 16'h401D
  };

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] s = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) s ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return s;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] x);
    if (x == 0) return 8'h00;
    for (int y = 1; y < 256; y++)
      if (gmul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] x, output logic [7:0] r, output int lat);
    @(negedge clk);
    start = 1'b1;
    opnd  = x;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    r = result;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int lat;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9 busy", busy, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(result == 8'h00, "R9 result", result, 0);

    // R1 R2: table of known pairs
    foreach (VEC[i]) begin
      run_op(VEC[i][15:8], r, lat);
      check(r == VEC[i][7:0], "R1/R2 table", r, VEC[i][7:0]);
      check(lat == LAT_NEG, "R5 latency", lat, LAT_NEG);
    end

    // R3 R4 R5: full sweep
    for (int x = 0; x < 256; x++) begin
      run_op(8'(x), r, lat);
      check(r == ref_inv(8'(x)), "R3 sweep", r, ref_inv(8'(x)));
      if (x != 0) check(gmul(8'(x), r) == 8'h01, "R4 product", gmul(8'(x), r), 1);
      check(lat == LAT_NEG, "R5 sweep latency", lat, LAT_NEG);
    end

    // R5: zero takes the full time
    run_op(8'h00, r, lat);
    check(lat == LAT_NEG && r == 8'h00, "R5 zero latency", lat, LAT_NEG);

    // R6: busy during run, done a single cycle
    @(negedge clk); start = 1'b1; opnd = 8'h10;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R6 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R6 busy low at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", done, 0);

    // R7: start while busy ignored
    @(negedge clk); start = 1'b1; opnd = 8'h02;
    @(negedge clk); start = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; opnd = 8'h03;
    @(negedge clk); start = 1'b0; lat++;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(result == 8'h8D, "R7 operand kept", result, 8'h8D);
    check(lat == LAT_NEG, "R7 timing kept", lat, LAT_NEG);

    // R8: result holds after completion
    repeat (6) @(negedge clk);
    check(result == 8'h8D && !done, "R8 hold", result, 8'h8D);
    @(negedge clk); start = 1'b1; opnd = 8'h95;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    check(result == 8'h8D, "R8 hold during run", result, 8'h8D);
    while (!done) @(negedge clk);
    check(result == 8'h8A, "R8 update at done", result, 8'h8A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule